// File: doc/BRIEF.md
# Five-Pin Multiplexed I/O Port Controller

This block manages a five-pin general-purpose port that sits on a small register bus. It has two registers. The first is a direction register that can only be written. The second is a data register that can be both read and written. When a direction bit is set, the port drives that pin. When it is clear, the port only senses the pin. Four of the pins do not drive from the data register when they are outputs. Instead they pass through chip-select strobes that other logic produces. The lowest pin can be handed to a refresh strobe through an external enable.

A read of the data register mixes two sources. Bits configured as outputs return the stored data. Bits configured as inputs return the pin level after it has passed a two-stage synchronizer. Hardware standby puts both registers back to their reset contents. Software standby freezes them, so any pin already driving keeps driving.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset, pin 4 is the only output, pins 3 to 0 are inputs (with refresh disabled), and a read of the data register returns 0xE0 with pins 3 to 0 replaced by their synchronized levels.
- R2: A pin from 4 down to 1 with its direction bit set has output-enable high and drives chip-select 0, 1, 2, 3 respectively, that is, pin 4 takes chip-select bit 0 and pin 1 takes chip-select bit 3.
- R3: A pin whose direction bit is clear, and which refresh does not override, has output-enable low.
- R4: While the refresh enable is high, pin 0 has output-enable high and drives the refresh input, whatever its direction bit.
- R5: While the refresh enable is low, the output-enable of pin 0 equals direction bit 0 and pin 0 drives data bit 0.
- R6: A read of the direction register (address 0) always returns 0xFF.
- R7: Data register (address 1) bits 7 to 5 read as 1 and ignore writes.
- R8: In a data register read, bit i (i from 0 to 4) returns the stored data bit when direction bit i is 1, and the synchronized pin level when it is 0. Any other address reads 0x00.
- R9: A change on a pin input appears in a data register read two clock edges later.
- R10: While hardware standby is high, each clock edge reloads direction 0x10 and data 0x00 (pins 4 to 0), and writes are ignored.
- R11: While software standby is high, writes are ignored and both registers keep their values, so the output enables stay unchanged.
- R12: A write takes effect on the clock edge at which the write enable is sampled. Reads are combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_stby | input | 1 | Hardware standby: reload the reset contents |
| sw_stby | input | 1 | Software standby: freeze the registers |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational |
| pad_in | input | 5 | Pin input levels |
| pad_oe | output | 5 | Per-pin output enable |
| pad_out | output | 5 | Per-pin output value |
| cs_strobe | input | 4 | Chip-select strobes 0 to 3 |
| rfsh_en | input | 1 | Hands pin 0 to the refresh strobe |
| rfsh_strobe | input | 1 | Refresh strobe value |

## Verification
The bench builds the block with its default parameters: a 2-bit address with the direction register at 0 and the data register at 1. This leaves addresses 2 and 3 unused, so the zero read-back of unmapped locations can be reached. Random traffic covers all four addresses, and it mixes refresh, both standby inputs and pin activity. This drives every direction pattern against both sources of a data read, and it exercises pin-0 ownership changes in the middle of a sequence.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
    localparam int NPIN   = 5;
    localparam int NCS    = 4;
    localparam int DW     = 8;
    localparam int NRSVD  = DW - NPIN;
    localparam int SYNC_N = 2;

    typedef struct packed {
        logic [NPIN-1:0] dir;
        logic [NPIN-1:0] dat;
    } port_regs_t;

    localparam logic [NPIN-1:0] DIR_RST = 5'b10000;
    localparam logic [NPIN-1:0] DAT_RST = 5'b00000;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= stg_d[s];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_mux_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int DIR_ADDR  = 0,
    parameter int DATA_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DW-1:0]     wdata,
    output port_regs_t        regs
);
    port_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (hw_stby) begin
            regs_d.dir = DIR_RST;
            regs_d.dat = DAT_RST;
        end else if (wr && !sw_stby) begin
            if (addr == ADDR_W'(DIR_ADDR))  regs_d.dir = wdata[NPIN-1:0];
            if (addr == ADDR_W'(DATA_ADDR)) regs_d.dat = wdata[NPIN-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.dir <= DIR_RST;
            regs_q.dat <= DAT_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs = regs_q;
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
    import gpio_mux_pkg::*;
(
    input  port_regs_t       regs,
    input  logic [NCS-1:0]   cs_strobe,
    input  logic             rfsh_en,
    input  logic             rfsh_strobe,
    output logic [NPIN-1:0]  oe,
    output logic [NPIN-1:0]  out
);
    // pin p (1..NCS) carries chip-select NPIN-1-p
    for (genvar p = 1; p < NPIN; p++) begin : g_cs_pin
        assign oe[p]  = regs.dir[p];
        assign out[p] = cs_strobe[NPIN-1-p];
    end

    always_comb begin
        if (rfsh_en) begin
            oe[0]  = 1'b1;
            out[0] = rfsh_strobe;
        end else begin
            oe[0]  = regs.dir[0];
            out[0] = regs.dat[0];
        end
    end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
    import gpio_mux_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int DIR_ADDR  = 0,
    parameter int DATA_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [4:0]        pad_in,
    output logic [4:0]        pad_oe,
    output logic [4:0]        pad_out,
    input  logic [3:0]        cs_strobe,
    input  logic              rfsh_en,
    input  logic              rfsh_strobe
);
    port_regs_t      regs;
    logic [NPIN-1:0] pin_sync;
    logic [NPIN-1:0] mixed;

    gpio_regs #(
        .ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR), .DATA_ADDR(DATA_ADDR)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata), .regs(regs)
    );

    gpio_sync #(.W(NPIN), .STAGES(SYNC_N)) sync_i (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
    );

    gpio_pinmux mux_i (
        .regs(regs), .cs_strobe(cs_strobe), .rfsh_en(rfsh_en),
        .rfsh_strobe(rfsh_strobe), .oe(pad_oe), .out(pad_out)
    );

    always_comb begin
        mixed = (regs.dat & regs.dir) | (pin_sync & ~regs.dir);
        if (reg_addr == ADDR_W'(DIR_ADDR))
            reg_rdata = '1;
        else if (reg_addr == ADDR_W'(DATA_ADDR))
            reg_rdata = {{NRSVD{1'b1}}, mixed};
        else
            reg_rdata = '0;
    end
endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk #(
    parameter int ADDR_W    = 2,
    parameter int DIR_ADDR  = 0,
    parameter int DATA_ADDR = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hw_stby,
    input logic              sw_stby,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [7:0]        reg_wdata,
    input logic [7:0]        reg_rdata,
    input logic [4:0]        pad_in,
    input logic [4:0]        pad_oe,
    input logic [4:0]        pad_out,
    input logic [3:0]        cs_strobe,
    input logic              rfsh_en,
    input logic              rfsh_strobe
);
    p_cs_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pad_out[4:1] == {cs_strobe[0], cs_strobe[1], cs_strobe[2], cs_strobe[3]});

    p_rfsh_pin0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_en |-> (pad_oe[0] && pad_out[0] == rfsh_strobe));

    p_dir_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(DIR_ADDR)) |-> (reg_rdata == 8'hFF));

    p_rsvd_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(DATA_ADDR)) |-> (reg_rdata[7:5] == 3'b111));

    p_hw_stby_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> (pad_oe[4:1] == 4'b1000 && (rfsh_en || !pad_oe[0])));

    p_sw_stby_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stby && !hw_stby) |=> $stable(pad_oe[4:1]));
endmodule

bind gpio_mux_port gpio_mux_port_chk #(
    .ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR), .DATA_ADDR(DATA_ADDR)
) chk_i (.*);

// File: tb/gpio_mux_port_tb_top.sv
module gpio_mux_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_stby = 1'b0, sw_stby = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [4:0] pad_in = '0, pad_oe, pad_out;
    logic [3:0] cs_strobe = '0;
    logic       rfsh_en = 1'b0, rfsh_strobe = 1'b0;

    always #2 clk = ~clk;

    gpio_mux_port dut_i (.*);

    int    n_cmp = 0, n_bad = 0;
    string tag = "R1";
    int    m_dir = 16, m_dat = 0;
    int    hist[$];

    // behavioural reference model, updated at every edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_dir = 16; m_dat = 0; hist.delete();
        end else begin
            hist.push_back(int'(pad_in));
            if (hist.size() > 2) void'(hist.pop_front());
            if (hw_stby) begin
                m_dir = 16; m_dat = 0;
            end else if (reg_wr && !sw_stby) begin
                if (reg_addr == 2'd0) m_dir = reg_wdata & 31;
                else if (reg_addr == 2'd1) m_dat = reg_wdata & 31;
            end
        end
    end

    task automatic check();
        int sy, e_oe, e_out, e_rd;
        sy    = (hist.size() == 2) ? hist[0] : 0;
        e_oe  = (m_dir & 30) | (rfsh_en ? 1 : (m_dir & 1));
        e_out = (cs_strobe[0] << 4) | (cs_strobe[1] << 3) | (cs_strobe[2] << 2)
              | (cs_strobe[3] << 1) | (rfsh_en ? rfsh_strobe : (m_dat & 1));
        if (reg_addr == 2'd0)      e_rd = 255;
        else if (reg_addr == 2'd1) e_rd = 224 | (((m_dat & m_dir) | (sy & ~m_dir)) & 31);
        else                       e_rd = 0;
        n_cmp += 3;
        if (int'(pad_oe) != e_oe) begin
            n_bad++; $display("FAIL %s pad_oe act=%h exp=%h t=%0t", tag, pad_oe, e_oe, $time);
        end
        if (int'(pad_out) != e_out) begin
            n_bad++; $display("FAIL %s pad_out act=%h exp=%h t=%0t", tag, pad_out, e_out, $time);
        end
        if (int'(reg_rdata) != e_rd) begin
            n_bad++; $display("FAIL %s reg_rdata act=%h exp=%h t=%0t", tag, reg_rdata, e_rd, $time);
        end
    endtask

    task automatic go(string t);
        tag = t;
        #1 check();
        @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d, string t);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        go(t);
        reg_wr = 1'b0;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        pad_in = 5'h0F; reg_addr = 2'd1;
        go("R1"); go("R1");
        rst_n = 1'b1;
        go("R1"); go("R9"); go("R9");            // sync latency after reset
        reg_addr = 2'd0; go("R6");
        reg_addr = 2'd2; go("R8");
        wr(2'd0, 8'h1F, "R12");                   // all pins output
        reg_addr = 2'd1; go("R12");
        cs_strobe = 4'b0101; go("R2");
        cs_strobe = 4'b1010; go("R2");
        wr(2'd1, 8'hFF, "R7");                    // reserved bits ignored
        reg_addr = 2'd1; go("R7");
        wr(2'd1, 8'h15, "R5"); reg_addr = 2'd1; go("R5");
        wr(2'd0, 8'h0F, "R8"); pad_in = 5'h0A; reg_addr = 2'd1;
        go("R8"); go("R9"); go("R9"); go("R8");
        wr(2'd0, 8'h00, "R3"); go("R3");
        rfsh_en = 1'b1; rfsh_strobe = 1'b1; go("R4");
        rfsh_strobe = 1'b0; go("R4");
        rfsh_en = 1'b0; go("R5");
        wr(2'd0, 8'h0B, "R12");
        sw_stby = 1'b1;
        wr(2'd0, 8'h10, "R11"); wr(2'd1, 8'h0E, "R11");
        reg_addr = 2'd1; go("R11"); go("R11");
        sw_stby = 1'b0; go("R11");
        hw_stby = 1'b1; wr(2'd0, 8'h1F, "R10"); go("R10");
        hw_stby = 1'b0; go("R10");
        for (int i = 0; i < 3000; i++) begin
            reg_addr    = 2'($urandom);
            reg_wr      = ($urandom % 3) == 0;
            reg_wdata   = 8'($urandom);
            pad_in      = 5'($urandom);
            cs_strobe   = 4'($urandom);
            rfsh_en     = ($urandom % 4) == 0;
            rfsh_strobe = 1'($urandom);
            sw_stby     = ($urandom % 10) == 0;
            hw_stby     = ($urandom % 40) == 0;
            go("R8");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule